// File: doc/BRIEF.md
# MSI Capability and Interrupt Write Generator

This block is the endpoint-side logic for message signaled interrupts. Configuration software reaches a four-dword capability structure through a small register port. The structure holds a fixed header, a control word, a 64-bit target address and a 16-bit base data pattern. Each interrupt source drives one event line. A rising edge on an event line marks that vector pending.

Once software has set the enable bit, the block serves pending vectors one at a time. Each one goes out as a single memory-write request on a valid/ready output. The request carries the programmed address and the base data word, with the vector number merged into the low bits. Software grants a power-of-two number of vectors, never more than the device advertises. Events on vectors beyond the grant share the highest granted vector's data value. Packet formatting is left to the downstream transaction layer.

Top module: `msi_irq_gen`

## Requirements
- R1: Dword 0 reads capability ID 0x05 in bits [7:0] and the `NEXT_PTR` parameter in bits [15:8]. The control word sits in bits [31:16]: enable in bit 16, the read-only requested-count field log2(`NUM_VEC`) in bits [19:17], the granted-count field in bits [22:20], and a 64-bit-capable bit in bit 23 that always reads 1. Writes to the ID, the pointer, the requested count and bit 23 have no effect.
- R2: Dword 1 holds address bits [31:2]. Bits [1:0] always read zero and are driven zero on every write request.
- R3: A granted-count write larger than the requested count is stored as the requested count.
- R4: After reset, the enable bit, the granted count, both address dwords and the data dword (dword 3, bits [15:0]; bits [31:16] read zero) read zero, no write request is valid, and no vector is pending.
- R5: While enable is clear, no write request is issued. Events seen in that time stay pending and are issued after enable is set.
- R6: A write request carries address {dword 2, dword 1}. Its data carries zero in bits [31:16]. In bits [15:0] it carries the base pattern, with its low G bits replaced by the vector number when 2^G vectors are granted.
- R7: A vector number at or above 2^G is encoded as 2^G-1.
- R8: Pending vectors are served lowest number first, with at most one request outstanding.
- R9: While valid is high and ready is low, valid, address and data hold.
- R10: A vector's pending bit clears when its request is accepted. An event line held high produces exactly one write.
- R11: Read data appears one cycle after the dword select. A write request becomes valid two clock edges after an event line first rises with enable set and the output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 2 | Capability dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data for the selected dword |
| evt_req | input | NUM_VEC | Per-vector event lines, rising-edge sensitive |
| mw_valid | output | 1 | Memory-write request valid |
| mw_ready | input | 1 | Memory-write request accepted when high with valid |
| mw_addr | output | 64 | Memory-write target address |
| mw_data | output | 32 | Memory-write data word |

## Verification
Reads are due one edge after the dword select, so the bench sets the select at a falling edge and samples at the next falling edge. A request becomes valid on the second rising edge after an event line is raised: one edge sets the pending bit and the next loads the output register. The latency test samples exactly there. The other tests poll at falling edges within a bounded window and check that nothing arrives early while enable is clear. After an accept, the next request can appear no sooner than the edge after that, so the order and count of writes are checked one request at a time.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [7:0] CAP_ID_MSI = 8'h05;
  localparam logic [1:0] DW_HDR  = 2'd0;
  localparam logic [1:0] DW_ALO  = 2'd1;
  localparam logic [1:0] DW_AHI  = 2'd2;
  localparam logic [1:0] DW_DATA = 2'd3;
  localparam int         EN_BIT  = 16;
  localparam int         MME_LSB = 20;
  localparam int         MMC_LSB = 17;
  localparam int         W64_BIT = 23;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_dw,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        msi_en,
  output logic [2:0]  mme,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_base
);
  localparam logic [2:0] MMC = 3'($clog2(NUM_VEC));

  logic [29:0] addr_lo_q;
  logic [31:0] addr_hi_q;
  logic [15:0] ctrl_word;
  logic [2:0]  mme_wr;
  logic [31:0] rd_mux;

  assign mme_wr = cfg_wdata[MME_LSB +: 3];

  always_ff @(posedge clk) begin
    if (rst) begin
      msi_en    <= 1'b0;
      mme       <= 3'd0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      msg_base  <= '0;
    end else if (cfg_we) begin
      case (cfg_dw)
        DW_HDR: begin
          msi_en <= cfg_wdata[EN_BIT];
          mme    <= (mme_wr > MMC) ? MMC : mme_wr;
        end
        DW_ALO:  addr_lo_q <= cfg_wdata[31:2];
        DW_AHI:  addr_hi_q <= cfg_wdata;
        default: msg_base  <= cfg_wdata[15:0];
      endcase
    end
  end

  assign ctrl_word = {8'h00, 1'b1, mme, MMC, msi_en};
  assign msg_addr  = {addr_hi_q, addr_lo_q, 2'b00};

  always_comb begin
    case (cfg_dw)
      DW_HDR:  rd_mux = {ctrl_word, NEXT_PTR, CAP_ID_MSI};
      DW_ALO:  rd_mux = {addr_lo_q, 2'b00};
      DW_AHI:  rd_mux = addr_hi_q;
      default: rd_mux = {16'h0000, msg_base};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/msi_pending.sv
module msi_pending #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] evt_req,
  input  logic [NUM_VEC-1:0] clr_vec,
  output logic [NUM_VEC-1:0] pending
);
  logic [NUM_VEC-1:0] evt_q;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    logic rise;
    assign rise = evt_req[i] & ~evt_q[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        evt_q[i]   <= 1'b0;
        pending[i] <= 1'b0;
      end else begin
        evt_q[i] <= evt_req[i];
        if (rise)            pending[i] <= 1'b1;
        else if (clr_vec[i]) pending[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msi_arbiter.sv
module msi_arbiter #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msi_en,
  input  logic [2:0]         mme,
  input  logic [63:0]        msg_addr,
  input  logic [15:0]        msg_base,
  input  logic [NUM_VEC-1:0] pending,
  input  logic               mw_ready,
  output logic               mw_valid,
  output logic [63:0]        mw_addr,
  output logic [31:0]        mw_data,
  output logic [NUM_VEC-1:0] clr_vec
);
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [VW-1:0] pick;
  logic [VW-1:0] cur_sel;
  logic [5:0]    gmax;
  logic [5:0]    vec_fold;
  logic [15:0]   lmask;
  logic [15:0]   enc_data;

  always_comb begin
    pick = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pending[i]) pick = VW'(i);
    end
  end

  assign gmax     = 6'((6'd1 << mme) - 6'd1);
  assign vec_fold = (6'(pick) > gmax) ? gmax : 6'(pick);
  assign lmask    = 16'(gmax);
  assign enc_data = (msg_base & ~lmask) | (16'(vec_fold) & lmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
      cur_sel  <= '0;
    end else if (mw_valid) begin
      if (mw_ready) mw_valid <= 1'b0;
    end else if (msi_en && (|pending)) begin
      mw_valid <= 1'b1;
      mw_addr  <= msg_addr;
      mw_data  <= {16'h0000, enc_data};
      cur_sel  <= pick;
    end
  end

  always_comb begin
    clr_vec = '0;
    if (mw_valid && mw_ready) clr_vec[cur_sel] = 1'b1;
  end
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen #(
  parameter int NUM_VEC = 8,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_dw,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_VEC-1:0] evt_req,
  output logic               mw_valid,
  input  logic               mw_ready,
  output logic [63:0]        mw_addr,
  output logic [31:0]        mw_data
);
  logic               msi_en;
  logic [2:0]         mme;
  logic [63:0]        msg_addr;
  logic [15:0]        msg_base;
  logic [NUM_VEC-1:0] pending;
  logic [NUM_VEC-1:0] clr_vec;

  msi_cap_regs #(.NUM_VEC(NUM_VEC), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msi_en(msi_en),
    .mme(mme), .msg_addr(msg_addr), .msg_base(msg_base)
  );

  msi_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst(rst), .evt_req(evt_req), .clr_vec(clr_vec),
    .pending(pending)
  );

  msi_arbiter #(.NUM_VEC(NUM_VEC)) u_arb (
    .clk(clk), .rst(rst), .msi_en(msi_en), .mme(mme),
    .msg_addr(msg_addr), .msg_base(msg_base), .pending(pending),
    .mw_ready(mw_ready), .mw_valid(mw_valid), .mw_addr(mw_addr),
    .mw_data(mw_data), .clr_vec(clr_vec)
  );
endmodule

// File: rtl/msi_irq_gen_chk.sv
module msi_irq_gen_chk #(
  parameter int NUM_VEC = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        mw_valid,
  input logic        mw_ready,
  input logic [63:0] mw_addr,
  input logic [31:0] mw_data,
  input logic        msi_en,
  input logic [2:0]  mme,
  input logic [1:0]  cfg_dw,
  input logic [31:0] cfg_rdata
);
  localparam logic [2:0] MMC = 3'($clog2(NUM_VEC));

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> mw_addr[1:0] == 2'b00); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data))); // R9

  AST_ISSUE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(mw_valid)) |-> $past(msi_en)); // R5

  AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (rst)
    mme <= MMC); // R3

  AST_DATA_UPPER: assert property (@(posedge clk) disable iff (rst)
    mw_valid |-> mw_data[31:16] == 16'h0000); // R6

  AST_HDR_ID: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_dw) == 2'd0) |-> (cfg_rdata[7:0] == 8'h05 && cfg_rdata[23])); // R1
endmodule

bind msi_irq_gen msi_irq_gen_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst(rst), .mw_valid(mw_valid), .mw_ready(mw_ready),
  .mw_addr(mw_addr), .mw_data(mw_data), .msi_en(msi_en), .mme(mme),
  .cfg_dw(cfg_dw), .cfg_rdata(cfg_rdata)
);

// File: tb/msi_irq_gen_test.sv
module msi_irq_gen_test;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_dw = 2'd0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NV-1:0] evt_req = '0;
  logic          mw_valid;
  logic          mw_ready = 1'b1;
  logic [63:0]   mw_addr;
  logic [31:0]   mw_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [63:0] ADDR = 64'h0000_0001_1000_0040;

  always #4 clk = ~clk;

  msi_irq_gen #(.NUM_VEC(NV), .NEXT_PTR(8'h00)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_req(evt_req),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] dw, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dw = dw; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] dw, output logic [31:0] d);
    @(negedge clk);
    cfg_dw = dw;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    @(negedge clk);
    evt_req = evt_req | m;
    @(negedge clk);
    evt_req = evt_req & ~m;
  endtask

  task automatic wait_write(input logic [31:0] exp_data, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (mw_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, req, {63'd0, seen}, 64'd1);
    chk(mw_addr == ADDR, req, mw_addr, ADDR);
    chk(mw_data == exp_data, req, {32'd0, mw_data}, {32'd0, exp_data});
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    cfg_read(2'd0, r);
    chk(r == 32'h0086_0005, "R1 R4 header", {32'd0, r}, 64'h0086_0005);
    cfg_read(2'd1, r);
    chk(r == 32'h0, "R4 addr lo", {32'd0, r}, 64'd0);
    cfg_read(2'd2, r);
    chk(r == 32'h0, "R4 addr hi", {32'd0, r}, 64'd0);
    cfg_read(2'd3, r);
    chk(r == 32'h0, "R4 data", {32'd0, r}, 64'd0);
    chk(mw_valid == 1'b0, "R4 valid", {63'd0, mw_valid}, 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    cfg_write(2'd1, 32'hFFFF_FFFF);
    cfg_read(2'd1, r);
    chk(r == 32'hFFFF_FFFC, "R2 align", {32'd0, r}, 64'hFFFF_FFFC);
    cfg_write(2'd0, 32'hFFFF_FFFF);
    cfg_read(2'd0, r);
    chk(r == 32'h00B7_0005, "R1 R3 clamp", {32'd0, r}, 64'h00B7_0005);
    cfg_write(2'd0, 32'h0000_0000);
    cfg_write(2'd3, 32'hFFFF_1234);
    cfg_read(2'd3, r);
    chk(r == 32'h0000_1234, "R4 data width", {32'd0, r}, 64'h1234);
  endtask

  task automatic t_disabled();
    logic [31:0] r;
    cfg_write(2'd1, ADDR[31:0]);
    cfg_write(2'd2, ADDR[63:32]);
    cfg_write(2'd3, 32'h0000_ABC0);
    cfg_write(2'd0, 32'h0020_0000);
    pulse(8'h02);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mw_valid) chk(1'b0, "R5 held while disabled", 64'd1, 64'd0);
    end
    chk(mw_valid == 1'b0, "R5 no write", {63'd0, mw_valid}, 64'd0);
    cfg_write(2'd0, 32'h0021_0000);
    wait_write(32'h0000_ABC1, "R5 R6 vector 1");
    cfg_read(2'd0, r);
    chk(r[22:20] == 3'd2, "R3 grant kept", {61'd0, r[22:20]}, 64'd2);
  endtask

  task automatic t_priority();
    logic [63:0] a0;
    logic [31:0] d0;
    mw_ready = 1'b0;
    pulse(8'h09);
    @(negedge clk);
    chk(mw_valid == 1'b1, "R8 first valid", {63'd0, mw_valid}, 64'd1);
    chk(mw_data == 32'h0000_ABC0, "R8 lowest first", {32'd0, mw_data}, 64'hABC0);
    a0 = mw_addr; d0 = mw_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(mw_valid && mw_addr == a0 && mw_data == d0, "R9 stall hold",
          {32'd0, mw_data}, {32'd0, d0});
    end
    mw_ready = 1'b1;
    @(negedge clk);
    chk(mw_valid == 1'b0, "R8 one outstanding", {63'd0, mw_valid}, 64'd0);
    wait_write(32'h0000_ABC3, "R8 second vector");
    chk(mw_valid == 1'b0, "R10 cleared", {63'd0, mw_valid}, 64'd0);
  endtask

  task automatic t_fold();
    pulse(8'h40);
    wait_write(32'h0000_ABC3, "R7 fold to 3");
    cfg_write(2'd0, 32'h0001_0000);
    pulse(8'h20);
    wait_write(32'h0000_ABC0, "R7 single vector");
  endtask

  task automatic t_level();
    int n = 0;
    logic [31:0] d = '0;
    cfg_write(2'd0, 32'h0031_0000);
    @(negedge clk);
    evt_req[2] = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (mw_valid && mw_ready) begin n++; d = mw_data; end
    end
    evt_req[2] = 1'b0;
    chk(n == 1, "R10 one write per edge", 64'(n), 64'd1);
    chk(d == 32'h0000_ABC2, "R6 three-bit merge", {32'd0, d}, 64'hABC2);
  endtask

  task automatic t_latency();
    @(negedge clk);
    evt_req[4] = 1'b1;
    @(negedge clk);
    chk(mw_valid == 1'b0, "R11 not yet", {63'd0, mw_valid}, 64'd0);
    @(negedge clk);
    chk(mw_valid == 1'b1, "R11 valid at second edge", {63'd0, mw_valid}, 64'd1);
    chk(mw_data == 32'h0000_ABC4, "R11 data", {32'd0, mw_data}, 64'hABC4);
    evt_req[4] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_disabled();
    t_priority();
    t_fold();
    t_level();
    t_latency();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule